// File: doc/BRIEF.md
# Multi-mode load address unit

This block carries out one load at a time. It forms the effective address in one of six ways, reads a single-port word memory that returns data one cycle after a read, and returns the loaded word tagged with the destination register index. A start strobe supplies the addressing mode, a signed constant, the base register value, the program counter of the load and the destination index. The unit stays busy until it presents the result.

Immediate loads return the sign-extended constant with no memory traffic. The direct, register, indexed and PC-relative forms each issue one read. The memory-indirect form issues two reads: the word returned by the first read becomes the address of the second. The post-increment form reads at the base value and also offers base+1 for write-back to the base register. Register-file access, decode, stores and any arithmetic on the loaded data belong to the surrounding pipeline.

Top module: `lau_load_unit`

## Requirements
- R1: After reset, busy, res_valid, res_err, mem_rd and wb_valid are all low.
- R2: Mode 0 (immediate) raises res_valid one cycle after the accepted start, with res_data equal to the sign-extended constant, and issues no memory read.
- R3: Mode 1 (direct) asserts mem_rd in the cycle after start at the sign-extended constant, and presents the returned word with res_valid one cycle later (2 cycles after start).
- R4: Mode 2 (register indirect) reads at the base value, with the same 2-cycle timing as R3.
- R5: Mode 3 (indexed) reads at base plus the sign-extended constant, modulo 2^ADDR_W, with a negative constant allowed.
- R6: Mode 4 (PC-relative) reads at pc + 1 + sign-extended constant, so a load at 200 with constant 30 reads address 231.
- R7: Mode 5 (memory indirect) reads at the sign-extended constant, then reads at the low ADDR_W bits of the returned word in the next cycle, and returns that second word 3 cycles after start.
- R8: Mode 6 (post-increment) reads at the base value. wb_valid is high for exactly the single result cycle with wb_val = base+1, and wb_valid is never high in any other mode.
- R9: Mode 7 is reserved. One cycle after start it raises res_valid and res_err with res_data zero, and issues no memory read.
- R10: A start strobe while busy is high is ignored. It produces no read and no result, and it does not disturb the load in flight.
- R11: res_dst equals the destination index captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (accepted only when idle) |
| mode | input | 3 | Addressing mode code |
| cnst | input | CONST_W | Signed constant field |
| dst_idx | input | IDX_W | Destination register index |
| base_val | input | ADDR_W | Base register value |
| pc | input | ADDR_W | Address of the load instruction |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rd | output | 1 | Memory read enable |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_rd |
| res_data | output | DATA_W | Loaded word |
| res_dst | output | IDX_W | Destination index of the result |
| res_valid | output | 1 | Result present this cycle |
| res_err | output | 1 | Reserved mode was requested |
| wb_val | output | ADDR_W | Incremented base for write-back |
| wb_valid | output | 1 | wb_val should be written |
| busy | output | 1 | A load is in flight |

## Verification
A wrong effective address shows at mem_addr in the first cycle after start, one cycle before the result. The scoreboard therefore compares each read address as soon as mem_rd rises. A corrupted sequencer state shows up as a result with the wrong latency, a read with no matching expectation, or a missing second read in memory-indirect mode, and each of these is caught within three cycles of the start. A lost capture of the destination or base shows at res_dst or wb_val in the result cycle.

// File: rtl/lau_pkg.sv
package lau_pkg;
  typedef enum logic [2:0] {
    M_IMM  = 3'd0,
    M_ABS  = 3'd1,
    M_REG  = 3'd2,
    M_IDX  = 3'd3,
    M_PCR  = 3'd4,
    M_MIND = 3'd5,
    M_POST = 3'd6,
    M_RSV  = 3'd7
  } lmode_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD1  = 3'd1,
    S_PTR  = 3'd2,
    S_DATA = 3'd3,
    S_IMM  = 3'd4,
    S_ERR  = 3'd5
  } lstate_e;
endpackage

// File: rtl/lau_ea_calc.sv
module lau_ea_calc #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CONST_W = 12
) (
  input  logic [2:0]         mode,
  input  logic [CONST_W-1:0] cnst,
  input  logic [ADDR_W-1:0]  base_val,
  input  logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  ea,
  output logic [DATA_W-1:0]  imm,
  output logic               needs_mem,
  output logic               is_ind,
  output logic               is_post,
  output logic               is_rsv
);
  import lau_pkg::*;

  function automatic logic [ADDR_W-1:0] sx_addr(input logic [CONST_W-1:0] c);
    return ADDR_W'($signed(c));
  endfunction

  function automatic logic [ADDR_W-1:0] wrap_add(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] b);
    return a + b;
  endfunction

  logic [ADDR_W-1:0] c_ext;
  assign c_ext = sx_addr(cnst);
  assign imm   = DATA_W'($signed(cnst));

  always_comb begin
    ea        = c_ext;
    needs_mem = 1'b1;
    is_ind    = 1'b0;
    is_post   = 1'b0;
    is_rsv    = 1'b0;
    case (lmode_e'(mode))
      M_IMM:  needs_mem = 1'b0;
      M_ABS:  ea = c_ext;
      M_REG:  ea = base_val;
      M_IDX:  ea = wrap_add(base_val, c_ext);
      M_PCR:  ea = wrap_add(wrap_add(pc, ADDR_W'(1)), c_ext);
      M_MIND: is_ind = 1'b1;
      M_POST: begin ea = base_val; is_post = 1'b1; end
      default: begin needs_mem = 1'b0; is_rsv = 1'b1; end
    endcase
  end
endmodule

// File: rtl/lau_seq.sv
module lau_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ea,
  input  logic [DATA_W-1:0] imm,
  input  logic              needs_mem,
  input  logic              is_ind,
  input  logic              is_post,
  input  logic              is_rsv,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [ADDR_W-1:0] base_val,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] res_data,
  output logic [IDX_W-1:0]  res_dst,
  output logic              res_valid,
  output logic              res_err,
  output logic [ADDR_W-1:0] wb_val,
  output logic              wb_valid,
  output logic              busy
);
  import lau_pkg::*;

  lstate_e           state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] imm_q;
  logic [IDX_W-1:0]  dst_q;
  logic [ADDR_W-1:0] wb_q;
  logic              post_q;
  logic              ind_q;

  // named internal events
  logic accept;
  logic ptr_phase;
  logic result_phase;

  assign accept       = start && (state == S_IDLE);
  assign ptr_phase    = (state == S_PTR);
  assign result_phase = (state == S_DATA) || (state == S_IMM) || (state == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      imm_q  <= '0;
      dst_q  <= '0;
      wb_q   <= '0;
      post_q <= 1'b0;
      ind_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          addr_q <= ea;
          imm_q  <= imm;
          dst_q  <= dst_idx;
          wb_q   <= base_val + ADDR_W'(1);
          post_q <= is_post;
          ind_q  <= is_ind;
          if (is_rsv)          state <= S_ERR;
          else if (!needs_mem) state <= S_IMM;
          else                 state <= S_RD1;
        end
        S_RD1:   state <= ind_q ? S_PTR : S_DATA;
        S_PTR:   state <= S_DATA;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_rd    = (state == S_RD1) || ptr_phase;
  assign mem_addr  = ptr_phase ? mem_rdata[ADDR_W-1:0] : addr_q;
  assign res_valid = result_phase;
  assign res_err   = (state == S_ERR);
  assign res_data  = (state == S_DATA) ? mem_rdata :
                     (state == S_IMM)  ? imm_q : '0;
  assign res_dst   = dst_q;
  assign wb_val    = wb_q;
  assign wb_valid  = (state == S_DATA) && post_q;
  assign busy      = (state != S_IDLE);

  // R3
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && needs_mem && !is_rsv) |=> (mem_rd && mem_addr == $past(ea)));

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !res_valid) |=> busy);

  // R8
  wb_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> res_valid);

  // R9
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> (res_data == '0 && !mem_rd));

  // R2
  result_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !busy);

  // R7
  ptr_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_phase |-> $past(mem_rd));
endmodule

// File: rtl/lau_load_unit.sv
module lau_load_unit #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CONST_W = 12,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         mode,
  input  logic [CONST_W-1:0] cnst,
  input  logic [IDX_W-1:0]   dst_idx,
  input  logic [ADDR_W-1:0]  base_val,
  input  logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [DATA_W-1:0]  res_data,
  output logic [IDX_W-1:0]   res_dst,
  output logic               res_valid,
  output logic               res_err,
  output logic [ADDR_W-1:0]  wb_val,
  output logic               wb_valid,
  output logic               busy
);
  logic [ADDR_W-1:0] ea;
  logic [DATA_W-1:0] imm;
  logic needs_mem, is_ind, is_post, is_rsv;

  lau_ea_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CONST_W(CONST_W)) i_ea (
    .mode(mode), .cnst(cnst), .base_val(base_val), .pc(pc),
    .ea(ea), .imm(imm), .needs_mem(needs_mem), .is_ind(is_ind),
    .is_post(is_post), .is_rsv(is_rsv)
  );

  lau_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .imm(imm),
    .needs_mem(needs_mem), .is_ind(is_ind), .is_post(is_post), .is_rsv(is_rsv),
    .dst_idx(dst_idx), .base_val(base_val),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .res_data(res_data), .res_dst(res_dst), .res_valid(res_valid),
    .res_err(res_err), .wb_val(wb_val), .wb_valid(wb_valid), .busy(busy)
  );
endmodule

// File: tb/test_lau_load_unit.sv
module test_lau_load_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0]  mode = '0;
  logic [11:0] cnst = '0;
  logic [2:0]  dst_idx = '0;
  logic [15:0] base_val = '0;
  logic [15:0] pc = '0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [15:0] mem_rdata = '0;
  logic [15:0] res_data;
  logic [2:0]  res_dst;
  logic        res_valid, res_err, wb_valid, busy;
  logic [15:0] wb_val;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  typedef struct {
    logic [15:0] data;
    logic [2:0]  dst;
    logic        err;
    logic        wbv;
    logic [15:0] wb;
    int          lat;
    int          t0;
    string       req;
  } exp_t;
  exp_t exq[$];
  logic [15:0] adq[$];
  string       adr_req[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] sx(input logic [11:0] c);
    return {{4{c[11]}}, c};
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  lau_load_unit i_lau_load_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .cnst(cnst),
    .dst_idx(dst_idx), .base_val(base_val), .pc(pc),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .res_data(res_data), .res_dst(res_dst), .res_valid(res_valid),
    .res_err(res_err), .wb_val(wb_val), .wb_valid(wb_valid), .busy(busy)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected reads and results
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) begin
        if (adq.size() == 0) chk(1'b0, "R2/R9/R10 unexpected read", {16'h0, mem_addr}, 32'h0);
        else begin
          logic [15:0] ea_e;
          string rq;
          ea_e = adq.pop_front();
          rq = adr_req.pop_front();
          chk(mem_addr == ea_e, rq, {16'h0, mem_addr}, {16'h0, ea_e});
        end
      end
      if (res_valid) begin
        if (exq.size() == 0) chk(1'b0, "R10 unexpected result", {16'h0, res_data}, 32'h0);
        else begin
          exp_t e;
          e = exq.pop_front();
          chk(res_data == e.data, e.req, {16'h0, res_data}, {16'h0, e.data});
          chk(res_dst == e.dst, "R11 dst", {29'h0, res_dst}, {29'h0, e.dst});
          chk(res_err == e.err, "R9 err flag", {31'h0, res_err}, {31'h0, e.err});
          chk(wb_valid == e.wbv, "R8 wb_valid", {31'h0, wb_valid}, {31'h0, e.wbv});
          if (e.wbv) chk(wb_val == e.wb, "R8 wb_val", {16'h0, wb_val}, {16'h0, e.wb});
          chk((cyc - e.t0) == e.lat, {e.req, " latency"}, cyc - e.t0, e.lat);
        end
      end else if (wb_valid) begin
        chk(1'b0, "R8 wb_valid outside result", 32'h1, 32'h0);
      end
    end
  end

  task automatic issue(input logic [2:0] m, input logic [11:0] c, input logic [15:0] b,
                       input logic [15:0] p, input logic [2:0] d);
    exp_t e;
    logic [15:0] a1;
    e.dst = d; e.err = 1'b0; e.wbv = 1'b0; e.wb = b + 16'd1; e.lat = 2; e.data = '0;
    case (m)
      3'd0: begin e.data = sx(c); e.lat = 1; e.req = "R2 immediate"; end
      3'd1: begin a1 = sx(c); e.req = "R3 direct"; end
      3'd2: begin a1 = b; e.req = "R4 register"; end
      3'd3: begin a1 = b + sx(c); e.req = "R5 indexed"; end
      3'd4: begin a1 = p + 16'd1 + sx(c); e.req = "R6 pc-relative"; end
      3'd5: begin a1 = sx(c); e.lat = 3; e.req = "R7 memory indirect"; end
      3'd6: begin a1 = b; e.wbv = 1'b1; e.req = "R8 post-increment"; end
      default: begin e.err = 1'b1; e.lat = 1; e.req = "R9 reserved"; end
    endcase
    if (m != 3'd0 && m != 3'd7) begin
      adq.push_back(a1); adr_req.push_back({e.req, " address"});
      if (m == 3'd5) begin
        adq.push_back(memf(a1)); adr_req.push_back("R7 second address");
        e.data = memf(memf(a1));
      end else e.data = memf(a1);
    end
    mode = m; cnst = c; base_val = b; pc = p; dst_idx = d;
    start = 1'b1; e.t0 = cyc;
    exq.push_back(e);
  endtask

  task automatic load(input logic [2:0] m, input logic [11:0] c, input logic [15:0] b,
                      input logic [15:0] p, input logic [2:0] d);
    @(negedge clk);
    issue(m, c, b, p, d);
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !res_valid && !res_err && !mem_rd && !wb_valid, "R1 reset state",
        {27'h0, busy, res_valid, res_err, mem_rd, wb_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    load(3'd0, 12'h7FF, 16'h0, 16'h0, 3'd1);        // R2 positive
    load(3'd0, 12'h800, 16'h0, 16'h0, 3'd2);        // R2 negative extends
    load(3'd1, 12'h123, 16'h0, 16'h0, 3'd3);        // R3
    load(3'd1, 12'hF00, 16'h0, 16'h0, 3'd4);        // R3 sign-extended address
    load(3'd2, 12'h0, 16'hBEEF, 16'h0, 3'd5);       // R4
    load(3'd3, 12'h020, 16'hFFF0, 16'h0, 3'd6);     // R5 wrap
    load(3'd3, 12'hFFE, 16'h0100, 16'h0, 3'd7);     // R5 negative constant
    load(3'd4, 12'd30, 16'h0, 16'd200, 3'd0);       // R6 200+1+30 = 231
    load(3'd4, 12'hFF0, 16'h0, 16'h4000, 3'd1);     // R6 backwards
    load(3'd5, 12'h0456, 16'h0, 16'h0, 3'd2);       // R7
    load(3'd5, 12'hC01, 16'h0, 16'h0, 3'd3);        // R7
    load(3'd6, 12'h0, 16'h1234, 16'h0, 3'd4);       // R8
    load(3'd6, 12'h0, 16'hFFFF, 16'h0, 3'd5);       // R8 wraps to 0
    load(3'd7, 12'h555, 16'h1, 16'h1, 3'd6);        // R9
    // R10: start held through the whole load, second request must be ignored
    @(negedge clk);
    issue(3'd5, 12'h077, 16'h0, 16'h0, 3'd7);
    @(negedge clk);
    mode = 3'd0; cnst = 12'h3A; dst_idx = 3'd1;     // start still high
    @(negedge clk);
    @(negedge clk);                                  // result cycle, start still high
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && exq.size() == 0, "R10 no extra load", {31'h0, busy}, 32'h0);
    chk(adq.size() == 0, "R10 all reads seen", adq.size(), 32'h0);
    load(3'd2, 12'h0, 16'h0042, 16'h0, 3'd2);       // R4 after ignored starts
    chk(exq.size() == 0, "R3 queue drained", exq.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5 * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule